// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block runs one acquisition group at a time for up to four analog channels: U, V, W and an auxiliary input. When it accepts a start strobe, it times a shared sample-and-hold window. It then walks the enabled channels one conversion slot at a time. For each slot it sends a one-clock request to an external converter and captures the word that converter returns. Each channel has its own result register, and a host reads these registers in any order through a small register port.

Two control bits set the group size, from two to four channels. V and W are always converted. The converter needs time to reacquire its inputs between groups. A start request that arrives during this gap is held back until the gap ends. A start request that arrives while a group is running is dropped. At the end of a group the block can raise an active-low interrupt, as a single-clock pulse or as a level. Reading the status register clears the status flags. In level mode that read also releases the interrupt line.

Top module: `adc_group_seq`

## Requirements
- R1: After a synchronous reset the status register (address 4) and the control register (address 5) both read 0, `irq_n_o` is high and `conv_start_o` is low. The control default selects only V and W, with the interrupt off and in pulse mode.
- R2: After reset is released, no group is accepted before the 21st rising edge. A start that is sampled earlier is held, so a start present at the first edge out of reset produces the first converter request 40 clocks after that edge.
- R3: When a start is sampled at edge E while the block is idle and ready, the acquisition window takes 20 clocks. `conv_start_o` is high in the cycle after edge E+20, each further channel request follows 40 clocks after the previous one, and a group of N channels completes at edge E+20+40·N.
- R4: Control bit 3 adds U and control bit 4 adds AUX. `conv_chan_o` carries U=0, V=1, W=2, AUX=3, and channels are requested in ascending code order.
- R5: Read addresses 0 to 3 return the result of the channel with that code, left-justified as {data[10:0], 0}. `rd_data_o` carries the value one clock after `rd_en_i` is sampled.
- R6: `conv_start_o` is a single-clock pulse. The word presented with `conv_done_i` inside a slot becomes that channel's result when the slot ends.
- R7: A start that is sampled while a group is in progress has no effect and is not queued.
- R8: After a group completes at edge C, a start sampled before edge C+21 is held, and the group it triggers is accepted at edge C+21.
- R9: With control bit 7 set, the end of a group sets status bits 0 and 11, so status reads 0x801, and drives `irq_n_o` low. With bit 7 clear, status stays 0 and `irq_n_o` stays high.
- R10: A status read returns the flags and clears them, so an immediate second read returns 0.
- R11: With control bit 8 clear, `irq_n_o` is low for exactly the one cycle after the completion edge.
- R12: With control bit 8 set, `irq_n_o` stays low until the status register is read, and is high from the cycle after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Group start strobe, sampled on each rising edge |
| ctl_wr_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 12 | Control word |
| rd_en_i | input | 1 | Register read enable |
| rd_addr_i | input | 3 | Read address: 0-3 results, 4 status, 5 control |
| rd_data_o | output | 12 | Registered read data |
| conv_start_o | output | 1 | One-clock conversion request to the converter |
| conv_chan_o | output | 2 | Channel code of the current request |
| conv_done_i | input | 1 | Converter word valid |
| conv_data_i | input | 11 | Converter word, two's complement |
| irq_n_o | output | 1 | Active-low end-of-group interrupt |

## Verification
The hardest situation to reach from the ports is the reacquisition hold-off. Reaching it needs a start that lands in the narrow window after a group has finished but before the gap has elapsed, and the bench must then tell a held start apart from one that was dropped. The stimulus reaches this point by counting clocks from the start strobe to the known completion edge and placing a second strobe three clocks later. The bench then checks that the next converter request appears exactly 41 clocks after completion. A separate strobe fired in the middle of a long group, followed by a long quiet stretch, shows that a start during a running group is not remembered.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int NCH = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} seq_st_e;
  typedef logic [1:0] chan_t;

  localparam chan_t CH_U   = 2'd0;
  localparam chan_t CH_V   = 2'd1;
  localparam chan_t CH_W   = 2'd2;
  localparam chan_t CH_AUX = 2'd3;

  // control and status bit positions seen by software
  localparam int CTL_U_BIT    = 3;
  localparam int CTL_AUX_BIT  = 4;
  localparam int CTL_IEN_BIT  = 7;
  localparam int CTL_LVL_BIT  = 8;
  localparam int STAT_ADC_BIT = 0;
  localparam int STAT_ANY_BIT = 11;

  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_CTL  = 3'd5;

  function automatic logic [NCH-1:0] chan_mask(logic u_en, logic aux_en);
    return {aux_en, 1'b1, 1'b1, u_en};
  endfunction

  // lowest enabled channel
  function automatic chan_t first_chan(logic [NCH-1:0] m);
    chan_t r = CH_V;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = chan_t'(i);
    return r;
  endfunction

  // lowest enabled channel above c (c itself when none)
  function automatic chan_t next_chan(logic [NCH-1:0] m, chan_t c);
    chan_t r = c;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i] && (i > int'(c))) r = chan_t'(i);
    return r;
  endfunction

  function automatic logic is_last(logic [NCH-1:0] m, chan_t c);
    logic l = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (m[i] && (i > int'(c))) l = 1'b0;
    return l;
  endfunction
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40,
  parameter int HOLD_CYC = 20,
  parameter int ABITS    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             u_en_i,
  input  logic             aux_en_i,
  input  logic             conv_done_i,
  input  logic [ABITS-1:0] conv_data_i,
  output logic             conv_start_o,
  output chan_t            conv_chan_o,
  output logic             res_we_o,
  output chan_t            res_ch_o,
  output logic [ABITS-1:0] res_data_o,
  output logic             grp_end_o,
  output logic             busy_o
);
  localparam int CMAX = (ACQ_CYC > CONV_CYC) ? ((ACQ_CYC > HOLD_CYC) ? ACQ_CYC : HOLD_CYC)
                                             : ((CONV_CYC > HOLD_CYC) ? CONV_CYC : HOLD_CYC);
  localparam int CW   = $clog2(CMAX + 1);

  seq_st_e          st;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    hold;
  logic             pend;
  logic [NCH-1:0]   mask;
  chan_t            ch;
  logic [ABITS-1:0] lat;

  logic go, slot_end;

  always_comb begin
    go         = (st == ST_IDLE) && (hold == '0) && (start_i || pend);
    slot_end   = (st == ST_CONV) && (cnt == '0);
    res_we_o   = slot_end;
    res_ch_o   = ch;
    res_data_o = conv_done_i ? conv_data_i : lat;
    grp_end_o  = slot_end && is_last(mask, ch);
    busy_o     = (st != ST_IDLE);
    conv_chan_o = ch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      hold         <= CW'(HOLD_CYC);
      pend         <= 1'b0;
      mask         <= chan_mask(1'b0, 1'b0);
      ch           <= CH_V;
      lat          <= '0;
      conv_start_o <= 1'b0;
    end else begin
      conv_start_o <= 1'b0;
      if ((st == ST_CONV) && conv_done_i) lat <= conv_data_i;
      if ((st == ST_IDLE) && (hold != '0)) hold <= hold - 1'b1;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st   <= ST_ACQ;
            cnt  <= CW'(ACQ_CYC - 1);
            pend <= 1'b0;
            mask <= chan_mask(u_en_i, aux_en_i);
          end else if (start_i && (hold != '0)) begin
            pend <= 1'b1;
          end
        end
        ST_ACQ: begin
          if (cnt == '0) begin
            st           <= ST_CONV;
            cnt          <= CW'(CONV_CYC - 1);
            ch           <= first_chan(mask);
            conv_start_o <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt == '0) begin
            if (is_last(mask, ch)) begin
              st   <= ST_IDLE;
              hold <= CW'(HOLD_CYC);
            end else begin
              ch           <= next_chan(mask, ch);
              cnt          <= CW'(CONV_CYC - 1);
              conv_start_o <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_regfile.sv
module adcseq_regfile
  import adcseq_pkg::*;
#(
  parameter int DW    = 12,
  parameter int ABITS = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_i,
  input  logic [DW-1:0]    ctl_wdata_i,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             res_we_i,
  input  chan_t            res_ch_i,
  input  logic [ABITS-1:0] res_data_i,
  input  logic             grp_end_i,
  output logic             irq_n_o,
  output logic             u_en_o,
  output logic             aux_en_o,
  output logic             ien_o,
  output logic             lvl_o
);
  localparam int PAD = DW - ABITS;

  logic [DW-1:0] res_mem [NCH];
  logic [DW-1:0] ctl_q;
  logic          st_adc, st_any;
  logic [DW-1:0] stat_vec;
  logic          set_flags, rd_stat;

  always_comb begin
    u_en_o    = ctl_q[CTL_U_BIT];
    aux_en_o  = ctl_q[CTL_AUX_BIT];
    ien_o     = ctl_q[CTL_IEN_BIT];
    lvl_o     = ctl_q[CTL_LVL_BIT];
    set_flags = grp_end_i && ien_o;
    rd_stat   = rd_en_i && (rd_addr_i == ADDR_STAT);
    stat_vec  = '0;
    stat_vec[STAT_ADC_BIT] = st_adc;
    stat_vec[STAT_ANY_BIT] = st_any;
  end

  // result storage, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (res_we_i) res_mem[res_ch_i] <= {res_data_i, {PAD{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (rd_addr_i < 3'd4)            rd_data_o <= res_mem[rd_addr_i[1:0]];
      else if (rd_addr_i == ADDR_STAT) rd_data_o <= stat_vec;
      else if (rd_addr_i == ADDR_CTL)  rd_data_o <= ctl_q;
      else                             rd_data_o <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      st_adc  <= 1'b0;
      st_any  <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      if (ctl_wr_i) ctl_q <= ctl_wdata_i;
      if (set_flags) begin
        st_adc <= 1'b1;
        st_any <= 1'b1;
      end else if (rd_stat) begin
        st_adc <= 1'b0;
        st_any <= 1'b0;
      end
      if (set_flags)            irq_n_o <= 1'b0;
      else if (!lvl_o || rd_stat) irq_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq
  import adcseq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int ABITS    = 11,
  parameter int ACQ_CYC  = 20,
  parameter int CONV_CYC = 40,
  parameter int HOLD_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             ctl_wr_i,
  input  logic [DW-1:0]    ctl_wdata_i,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             conv_start_o,
  output logic [1:0]       conv_chan_o,
  input  logic             conv_done_i,
  input  logic [ABITS-1:0] conv_data_i,
  output logic             irq_n_o
);
  logic             u_en, aux_en, irq_en, lvl_mode;
  logic             res_we, grp_end, busy;
  chan_t            res_ch, req_ch;
  logic [ABITS-1:0] res_data;

  assign conv_chan_o = req_ch;

  adcseq_ctrl #(
    .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC), .HOLD_CYC(HOLD_CYC), .ABITS(ABITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .u_en_i(u_en), .aux_en_i(aux_en),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .conv_start_o(conv_start_o), .conv_chan_o(req_ch),
    .res_we_o(res_we), .res_ch_o(res_ch), .res_data_o(res_data),
    .grp_end_o(grp_end), .busy_o(busy)
  );

  adcseq_regfile #(.DW(DW), .ABITS(ABITS)) u_regs (
    .clk(clk), .rst(rst),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .res_we_i(res_we), .res_ch_i(res_ch), .res_data_i(res_data),
    .grp_end_i(grp_end), .irq_n_o(irq_n_o),
    .u_en_o(u_en), .aux_en_o(aux_en), .ien_o(irq_en), .lvl_o(lvl_mode)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
  import adcseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       conv_start_o,
  input logic       irq_n_o,
  input logic       rd_en_i,
  input logic [2:0] rd_addr_i,
  input logic       grp_end,
  input logic       irq_en,
  input logic       lvl_mode,
  input logic       busy
);
  // R6
  conv_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  // R9
  irq_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_end && irq_en) |=> !irq_n_o);

  // R11
  edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o && !lvl_mode && !grp_end) |=> irq_n_o);

  // R12
  lvl_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (rd_addr_i == ADDR_STAT) && !grp_end) |=> irq_n_o);

  // R3
  grp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    grp_end |=> !busy);
endmodule

bind adc_group_seq adcseq_chk u_chk (
  .clk(clk), .rst(rst), .conv_start_o(conv_start_o), .irq_n_o(irq_n_o),
  .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .grp_end(grp_end),
  .irq_en(irq_en), .lvl_mode(lvl_mode), .busy(busy)
);

// File: tb/test_adc_group_seq.sv
module test_adc_group_seq;
  import adcseq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        ctl_wr_i = 1'b0;
  logic [11:0] ctl_wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [11:0] rd_data_o;
  logic        conv_start_o;
  logic [1:0]  conv_chan_o;
  logic        conv_done_i = 1'b0;
  logic [10:0] conv_data_i = '0;
  logic        irq_n_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  adc_group_seq i_adc_group_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .irq_n_o(irq_n_o)
  );

  // converter stub: answers each request 5 clocks later with a fixed word
  logic [10:0] stub_val [4];
  int          stub_cnt = 0;
  logic [1:0]  stub_ch  = '0;
  always @(posedge clk) begin
    conv_done_i <= 1'b0;
    if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        conv_done_i <= 1'b1;
        conv_data_i <= stub_val[stub_ch];
      end
    end
    if (conv_start_o) begin
      stub_cnt <= 5;
      stub_ch  <= conv_chan_o;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic [2:0] a, output int d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    d = int'(rd_data_o);
    rd_en_i = 1'b0;
  endtask

  task automatic reg_write(input logic [11:0] v);
    ctl_wr_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  function automatic int grp_len(bit u, bit aux);
    return 2 + int'(u) + int'(aux);
  endfunction

  function automatic int exp_ch(bit u, bit aux, int k);
    int l [4];
    int n = 0;
    if (u) begin l[n] = 0; n++; end
    l[n] = 1; n++;
    l[n] = 2; n++;
    if (aux) begin l[n] = 3; n++; end
    return l[k];
  endfunction

  function automatic logic [11:0] ctl_word(bit u, bit aux, bit ien, bit lvl);
    logic [11:0] w = '0;
    w[3] = u; w[4] = aux; w[7] = ien; w[8] = lvl;
    return w;
  endfunction

  task automatic run_group(bit u, bit aux, bit ien, bit lvl, bit poke);
    int n, done_idx, lim, nreq, nlow, first_low, d;
    int req_idx [8];
    int req_ch  [8];
    n = grp_len(u, aux);
    done_idx = 21 + 40 * n;
    lim = done_idx + 3;
    nreq = 0; nlow = 0; first_low = -1;
    reg_write(ctl_word(u, aux, ien, lvl));
    repeat (25) @(negedge clk);
    for (int c = 0; c < 4; c++) stub_val[c] = 11'($urandom);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= lim; i++) begin
      if (conv_start_o && nreq < 8) begin
        req_idx[nreq] = i; req_ch[nreq] = int'(conv_chan_o); nreq++;
      end
      if (!irq_n_o) begin
        if (first_low < 0) first_low = i;
        nlow++;
      end
      start_i = (poke && i == 50);
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R4 request count", nreq, n);
    for (int k = 0; k < n && k < nreq; k++) begin
      check("R3 request timing", req_idx[k], 21 + 40 * k);
      check("R4 channel order", req_ch[k], exp_ch(u, aux, k));
    end
    if (!ien) begin
      check("R9 no irq when disabled", nlow, 0);
    end else begin
      check("R9 irq at completion", first_low, done_idx);
      if (!lvl) check("R11 pulse width", nlow, 1);
      else      check("R12 irq held low", nlow, lim - done_idx + 1);
    end
    for (int k = 0; k < n; k++) begin
      reg_read(3'(exp_ch(u, aux, k)), d);
      check("R5 R6 result word", d, int'({stub_val[exp_ch(u, aux, k)], 1'b0}));
    end
    if (ien && lvl) check("R12 low before read", int'(irq_n_o), 0);
    reg_read(ADDR_STAT, d);
    check("R9 status value", d, ien ? 32'h801 : 0);
    if (ien && lvl) check("R12 released after read", int'(irq_n_o), 1);
    reg_read(ADDR_STAT, d);
    check("R10 status cleared", d, 0);
    if (poke) begin
      nreq = 0;
      for (int i = 0; i < 80; i++) begin
        if (conv_start_o) nreq++;
        @(negedge clk);
      end
      check("R7 busy start dropped", nreq, 0);
    end
  endtask

  task automatic pend_test();
    int first_req;
    first_req = -1;
    reg_write(ctl_word(1'b0, 1'b0, 1'b0, 1'b0));
    repeat (25) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // two-channel group completes at index 101
    for (int i = 1; i <= 170; i++) begin
      if (i > 101 && conv_start_o && first_req < 0) first_req = i;
      start_i = (i == 104);
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R8 held start timing", first_req, 142);
    repeat (120) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int d, first_req;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq idle", int'(irq_n_o), 1);
    check("R1 no request", int'(conv_start_o), 0);
    reg_read(ADDR_STAT, d);
    check("R1 status zero", d, 0);
    reg_read(ADDR_CTL, d);
    check("R1 control zero", d, 0);

    // R2: start held out of reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    first_req = -1;
    for (int i = 1; i <= 60; i++) begin
      if (conv_start_o && first_req < 0) first_req = i;
      @(negedge clk);
    end
    check("R2 first request after reset", first_req, 41);
    repeat (150) @(negedge clk);

    run_group(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_group(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    run_group(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_group(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    pend_test();
    for (int r = 0; r < 6; r++) begin
      logic [3:0] b;
      b = 4'($urandom);
      run_group(b[0], b[1], b[2], b[3], 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule